// File: doc/BRIEF.md
# Training Pattern Lock Detector

This block watches a receive bit stream that has already been recovered in clock and data phase, and decides whether the far end is sending a known training pattern. Software or a link state machine picks one of four fixed patterns with a 2-bit code. The patterns are a 20-bit long run pattern and three 8-bit patterns. The block searches the incoming bits for any rotation of the chosen pattern. When it finds one, it fixes that rotation as the word offset and then follows the stream bit by bit. Once the pattern has repeated 256 times without a break, it raises a lock flag.

The reported offset is what the downstream word aligner needs. Phase recovery puts the sampling point in the middle of each bit, but it does not place the word boundary. The offset tells the aligner how far into the pattern period the stream was when the match was found. If the pattern breaks, the block drops back to searching. If lock was already held when the pattern broke, it also raises a one-cycle error pulse.

The bit input is a valid/ready stream. The block never applies back-pressure: `in_ready` is always high, and one bit is taken on every clock edge where `in_valid` is high. A cycle with `in_valid` low is a bubble and leaves all state untouched.

Top module: `tpl_lock_detect`

## Requirements
- R1: `pat_sel` chooses the pattern, written here with the first received bit on the left. Code 0 is 00000000001111111111 (period 20). Code 1 is 00001111. Code 2 is 10010000. Code 3 is 10101010. Codes 1 to 3 have period 8.
- R2: `in_ready` is 1 at all times. A bit is taken only on an edge where `in_valid` is 1. An edge with `in_valid` at 0 leaves `locked` and `offset` unchanged and keeps `err` at 0.
- R3: After reset, a pattern change or a restart, a match can occur at the earliest on the P-th taken bit, where P is the period. A match means that the last P taken bits equal the pattern started at index k and wrapped, with index 0 being the leftmost bit in R1. `offset` then shows k, and the smallest k is chosen when several rotations fit. Until the first match, `offset` is 0.
- R4: `locked` rises on the edge that takes bit number 256·P counted from the first bit of the matching window, provided every bit followed the pattern. After 256·P−1 such bits it is still 0.
- R5: A bit that breaks the pattern after the match but before lock restarts the search. `offset` returns to 0, `err` stays 0, and a new match needs P fresh bits.
- R6: A bit that breaks the pattern while `locked` is 1 clears `locked` and sets `err` for exactly one cycle, on the same edge. `offset` returns to 0.
- R7: A change of `pat_sel` clears `locked`, `offset` and all counters on the next edge, without an error pulse. A bit offered in that cycle is discarded.
- R8: Synchronous reset `rst` clears `locked`, `err` and `offset` to 0.
- R9: While the pattern keeps matching, `locked` stays 1 past the 256th repetition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A bit is offered on in_bit |
| in_ready | output | 1 | Always 1; the block accepts every offered bit |
| in_bit | input | 1 | Received bit |
| pat_sel | input | 2 | Pattern code (R1) |
| locked | output | 1 | Pattern repeated 256 times unbroken |
| offset | output | 5 | Pattern index of the oldest bit in the matching window |
| err | output | 1 | One-cycle pulse when a locked pattern breaks |

## Verification
The bench starts each pattern at a non-zero index so that the reported rotation is unambiguous. For the alternating pattern, several rotations fit the window, and a design without the lowest-index priority would report 3, 5 or 7 instead of 1.

It samples `locked` one bit before and exactly at 256 repetitions. An off-by-one repetition counter would therefore show up as early or late lock.

Pattern breaks are sent both before and after lock. A design that pulsed `err` on an unlocked break, or kept a stale offset, would be caught. A pattern-select change while locked is also checked: a design that kept its state across the change would still report lock.

Bubbles are placed in a locked stream. A design that took a bit while `in_valid` was low would break the pattern and drop lock.

// File: rtl/tpl_pkg.sv
package tpl_pkg;
  localparam int unsigned PMAX = 20;                 // longest pattern period
  localparam int unsigned IW   = $clog2(PMAX + 1);   // index / length width

  typedef logic [PMAX-1:0] pat_t;                    // bit i = pattern index i

  typedef enum logic [1:0] {
    SEL_RUN10  = 2'd0,
    SEL_NIB4   = 2'd1,
    SEL_SPARSE = 2'd2,
    SEL_ALT    = 2'd3
  } pat_sel_e;

  typedef enum logic {
    ST_SEEK  = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_e;
endpackage

// File: rtl/tpl_pattern_rom.sv
module tpl_pattern_rom
  import tpl_pkg::*;
(
  input  logic [1:0]    sel,
  output pat_t          pat,
  output logic [IW-1:0] plen
);
  // R1: index 0 is the first bit received in each period
  always_comb begin
    pat  = '0;
    plen = IW'(8);
    case (pat_sel_e'(sel))
      SEL_RUN10:  begin pat = pat_t'(20'hFFC00); plen = IW'(20); end
      SEL_NIB4:   pat = pat_t'(8'hF0);
      SEL_SPARSE: pat = pat_t'(8'h09);
      default:    pat = pat_t'(8'h55);
    endcase
  end
endmodule

// File: rtl/tpl_align_search.sv
module tpl_align_search
  import tpl_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  input  pat_t          pat,
  input  logic [IW-1:0] plen,
  output logic          hit,
  output logic [IW-1:0] hit_off
);
  pat_t hist;        // hist[j] = bit taken j bits before the newest
  pat_t nwin;
  logic [PMAX-1:0] rot_ok;

  assign nwin = {hist[PMAX-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else if (in_valid) hist <= nwin;
  end

  function automatic logic rot_match(input int k, input pat_t w, input pat_t p, input int n);
    logic ok;
    int   idx;
    ok  = (k < n);
    idx = 0;
    for (int i = 0; i < PMAX; i++) begin
      if (i < n) begin
        idx = i + k;
        if (idx >= n) idx = idx - n;
        if (idx < PMAX && w[n-1-i] != p[idx]) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  for (genvar k = 0; k < PMAX; k++) begin : g_rot
    assign rot_ok[k] = rot_match(k, nwin, pat, int'(plen));
  end

  // lowest rotation wins
  always_comb begin
    hit_off = '0;
    for (int k = PMAX - 1; k >= 0; k--)
      if (rot_ok[k]) hit_off = IW'(k);
  end
  assign hit = |rot_ok;

  assert_hit_in_period_R3: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_off < plen));
endmodule

// File: rtl/tpl_tracker.sv
module tpl_tracker
  import tpl_pkg::*;
#(
  parameter int unsigned REPS = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic [1:0]    sel,
  input  pat_t          pat,
  input  logic [IW-1:0] plen,
  input  logic          hit,
  input  logic [IW-1:0] hit_off,
  output logic          locked,
  output logic [IW-1:0] offset,
  output logic          err
);
  localparam int unsigned RW = $clog2(REPS + 1);

  trk_state_e    state;
  logic [1:0]    sel_q;
  logic [IW-1:0] fill, ph, cnt;
  logic [RW-1:0] reps;
  logic [IW-1:0] lastp;
  logic          sel_chg;

  assign lastp   = plen - IW'(1);
  assign sel_chg = (sel != sel_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SEEK;
      sel_q  <= sel;
      fill   <= '0;
      ph     <= '0;
      cnt    <= '0;
      reps   <= '0;
      offset <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= 1'b0;
      if (sel_chg) begin                       // R7
        sel_q  <= sel;
        state  <= ST_SEEK;
        fill   <= '0;
        ph     <= '0;
        cnt    <= '0;
        reps   <= '0;
        offset <= '0;
        locked <= 1'b0;
      end else if (in_valid) begin
        if (state == ST_SEEK) begin
          if (fill >= lastp && hit) begin      // R3
            state  <= ST_TRACK;
            offset <= hit_off;
            ph     <= hit_off;
            cnt    <= '0;
            reps   <= RW'(1);
            locked <= (REPS == 1);
          end else if (fill < lastp) begin
            fill <= fill + IW'(1);
          end
        end else if (in_bit == pat[ph]) begin
          ph <= (ph == lastp) ? '0 : ph + IW'(1);
          if (cnt == lastp) begin              // one more full period
            cnt <= '0;
            if (reps < RW'(REPS)) reps <= reps + RW'(1);
            if (reps >= RW'(REPS - 1)) locked <= 1'b1;   // R4
          end else begin
            cnt <= cnt + IW'(1);
          end
        end else begin                         // R5 / R6
          state  <= ST_SEEK;
          fill   <= '0;
          ph     <= '0;
          cnt    <= '0;
          reps   <= '0;
          offset <= '0;
          locked <= 1'b0;
          err    <= locked;
        end
      end
    end
  end

  assert_err_single_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
  assert_err_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> (!locked && offset == '0));
  assert_lock_tracking_R4: assert property (@(posedge clk) disable iff (rst)
    locked |-> (state == ST_TRACK));
  assert_offset_range_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRACK && !sel_chg) |-> (offset < plen));
  assert_bubble_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !sel_chg) |=> ($stable(locked) && $stable(offset) && !err));
  assert_sel_clear_R7: assert property (@(posedge clk) disable iff (rst)
    sel_chg |=> (!locked && offset == '0 && !err));
endmodule

// File: rtl/tpl_lock_detect.sv
module tpl_lock_detect
  import tpl_pkg::*;
#(
  parameter int unsigned REPS = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  input  logic [1:0]    pat_sel,
  output logic          locked,
  output logic [IW-1:0] offset,
  output logic          err
);
  pat_t          pat;
  logic [IW-1:0] plen;
  logic          hit;
  logic [IW-1:0] hit_off;

  assign in_ready = 1'b1;   // R2: never back-pressures

  tpl_pattern_rom u_rom (
    .sel  (pat_sel),
    .pat  (pat),
    .plen (plen)
  );

  tpl_align_search u_search (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .pat      (pat),
    .plen     (plen),
    .hit      (hit),
    .hit_off  (hit_off)
  );

  tpl_tracker #(.REPS(REPS)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_bit   (in_bit),
    .sel      (pat_sel),
    .pat      (pat),
    .plen     (plen),
    .hit      (hit),
    .hit_off  (hit_off),
    .locked   (locked),
    .offset   (offset),
    .err      (err)
  );
endmodule

// File: tb/sim_tpl_lock_detect.sv
module sim_tpl_lock_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic [1:0] pat_sel = 2'd1;
  logic       locked;
  logic [4:0] offset;
  logic       err;

  int n_run = 0;
  int n_fail = 0;
  int idx = 0;

  always #5 clk = ~clk;

  tpl_lock_detect u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .pat_sel(pat_sel), .locked(locked), .offset(offset), .err(err)
  );

  function automatic int plen_of(input logic [1:0] s);
    return (s == 2'd0) ? 20 : 8;
  endfunction

  function automatic logic pbit(input logic [1:0] s, input int i);
    case (s)
      2'd0:    return i >= 10;
      2'd1:    return i >= 4;
      2'd2:    return (i == 0) || (i == 3);
      default: return (i % 2) == 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic b);
    in_valid = 1'b1;
    in_bit   = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_pat(input int n);
    for (int j = 0; j < n; j++) begin
      send(pbit(pat_sel, idx));
      idx = (idx + 1) % plen_of(pat_sel);
    end
  endtask

  task automatic use_sel(input logic [1:0] s, input int start);
    pat_sel = s;
    idle(1);
    idx = start;
  endtask

  task automatic t_reset;
    idle(2);
    chk("R8", "locked in reset", int'(locked), 0);
    chk("R8", "err in reset", int'(err), 0);
    chk("R8", "offset in reset", int'(offset), 0);
    chk("R2", "in_ready", int'(in_ready), 1);
    rst = 1'b0;
    idle(1);
  endtask

  task automatic t_nibble;
    use_sel(2'd1, 5);
    send_pat(7);
    chk("R3", "offset before P bits", int'(offset), 0);
    send_pat(1);
    chk("R3", "offset at P bits", int'(offset), 5);
    chk("R4", "locked at first match", int'(locked), 0);
    send_pat(256*8 - 8 - 1);
    chk("R4", "locked one bit early", int'(locked), 0);
    send_pat(1);
    chk("R4", "locked at 256 reps", int'(locked), 1);
    idle(3);
    chk("R2", "locked over bubbles", int'(locked), 1);
    chk("R2", "offset over bubbles", int'(offset), 5);
    chk("R2", "err over bubbles", int'(err), 0);
    send_pat(16);
    chk("R9", "locked after more reps", int'(locked), 1);
    send(!pbit(pat_sel, idx));
    chk("R6", "locked after break", int'(locked), 0);
    chk("R6", "err after break", int'(err), 1);
    chk("R6", "offset after break", int'(offset), 0);
    idle(1);
    chk("R6", "err one cycle", int'(err), 0);
  endtask

  task automatic t_run10;
    use_sel(2'd0, 13);
    send_pat(19);
    chk("R1", "run10 offset before P", int'(offset), 0);
    send_pat(1);
    chk("R1", "run10 offset", int'(offset), 13);
    send_pat(256*20 - 20 - 1);
    chk("R4", "run10 locked early", int'(locked), 0);
    send_pat(1);
    chk("R4", "run10 locked", int'(locked), 1);
  endtask

  task automatic t_sparse;
    use_sel(2'd2, 6);
    send_pat(8);
    chk("R1", "sparse offset", int'(offset), 6);
    send_pat(30);
    send(!pbit(pat_sel, idx));
    chk("R5", "err on unlocked break", int'(err), 0);
    chk("R5", "offset cleared", int'(offset), 0);
    chk("R5", "locked after break", int'(locked), 0);
    idx = 2;
    send_pat(8);
    chk("R5", "new offset after restart", int'(offset), 2);
  endtask

  task automatic t_alt;
    use_sel(2'd3, 1);
    send_pat(8);
    chk("R3", "alt lowest rotation", int'(offset), 1);
    send_pat(256*8 - 8);
    chk("R1", "alt locked", int'(locked), 1);
  endtask

  task automatic t_selchg;
    pat_sel  = 2'd1;
    in_valid = 1'b1;
    in_bit   = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7", "locked after select change", int'(locked), 0);
    chk("R7", "offset after select change", int'(offset), 0);
    chk("R7", "err after select change", int'(err), 0);
    idx = 2;
    send_pat(8);
    chk("R7", "offset for new select", int'(offset), 2);
  endtask

  task automatic t_rst_mid;
    rst = 1'b1;
    idle(1);
    chk("R8", "offset after mid reset", int'(offset), 0);
    chk("R8", "locked after mid reset", int'(locked), 0);
    rst = 1'b0;
    idle(1);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_nibble();
    t_run10();
    t_sparse();
    t_alt();
    t_selchg();
    t_rst_mid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule